// File: doc/BRIEF.md
# I2C Register-Access Slave with Auto-Increment Pointer

This block is an I2C target front end. It gives a bus controller byte-wide access to a 16-entry register file that sits outside the block. The block watches oversampled SCL and SDA in the system clock domain and finds START, repeated START and STOP conditions. It compares the first byte of each transfer with a fixed 7-bit address and then either accepts or returns data bytes. It pulls SDA low through an open-drain enable, both for acknowledges and for the zero bits of the data it returns.

A single 4-bit register pointer is shared by all transfers. A write transfer loads the pointer from its first byte after the address. Every data byte then goes to the pointer position, and the pointer moves on by one. To read from a chosen register, the controller writes the pointer, issues a repeated START and continues in read mode. A read that opens directly in read mode continues from wherever the pointer was left, and the pointer keeps its value through STOP. The pointer wraps from 15 to 0.

Top module: `i2c_reg_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and it always restarts address reception. STOP is SDA rising while SCL is high. STOP ends the transfer and leaves SDA released.
- R2: The address byte is sent MSB first, as seven address bits and then the direction bit (0 = write, 1 = read). When the seven bits equal SLV_ADDR, the slave pulls SDA low during the ninth clock.
- R3: On an address mismatch the slave drives no acknowledge, writes no register and drives SDA on no later clock until the next START.
- R4: In a write transfer the byte after the address loads the pointer. Each later byte is written to the register at the pointer, and the slave acknowledges every byte it receives.
- R5: The pointer advances by one after every data byte written or read, and it wraps from 15 to 0.
- R6: After a pointer write, a repeated START and a read-mode address, the first byte returned is the register at the loaded pointer, sent MSB first.
- R7: While the controller acknowledges with 0, the slave returns the following registers in order.
- R8: After a controller NACK (1), the slave releases SDA and drives nothing until the next START.
- R9: The pointer resets to 0 and keeps its value through STOP. A transfer that opens in read mode starts at the register after the last one accessed.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Each received data byte produces exactly one single-cycle register write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 4 | Register index, the current pointer |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data at reg_addr_o |

## Verification
The hardest situation to reach from the ports is a read with no pointer phase. Its expected start register depends on the whole history of earlier transfers, including wrap-around and reads that ended in NACK. The bench therefore runs a fixed-seed random mix of write bursts, pointer-plus-repeated-START reads and pointer-less reads, and it tracks the pointer in its own model so that every pointer-less read is predicted. Directed cases add a burst that crosses the wrap point, bus clocks after a NACK, and transfers to a foreign address.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REG, ST_REG_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o == '1) |=> (ptr_o == '0));
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h32,
  parameter int         DW       = 8,
  parameter int         AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          ptr_load_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          ptr_inc_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  slv_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          rw_q, mack_q, oe_q, we_q, ld_q, rinc_q;
  logic [AW-1:0] ld_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b1;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      ld_q     <= 1'b0;
      rinc_q   <= 1'b0;
      ld_val_q <= '0;
    end else begin
      we_q   <= 1'b0;
      ld_q   <= 1'b0;
      rinc_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[DW-1:1] == SLV_ADDR) begin
                  rw_q    <= sh_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_REG) begin
                ld_q     <= 1'b1;
                ld_val_q <= sh_q[AW-1:0];
                oe_q     <= 1'b1;
                state_q  <= ST_REG_ACK;
              end else begin
                we_q    <= 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= rdata_i;
                oe_q    <= ~rdata_i[DW-1];
                state_q <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_REG;
              end
            end
          end
          ST_REG_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                oe_q    <= 1'b0;
                rinc_q  <= 1'b1;
                cnt_q   <= '0;
                state_q <= ST_RACK;
              end else if (cnt_q != '0) begin
                sh_q <= {sh_q[DW-2:0], 1'b0};
                oe_q <= ~sh_q[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (!mack_q) begin
                sh_q    <= rdata_i;
                oe_q    <= ~rdata_i[DW-1];
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign we_o       = we_q;
  assign wdata_o    = sh_q;
  assign ptr_load_o = ld_q;
  assign ptr_val_o  = ld_val_q;
  assign ptr_inc_o  = we_q | rinc_q;

  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !oe_q);
  assert_mismatch_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && scl_fall_i && cnt_q == LAST && sh_q[DW-1:1] != SLV_ADDR)
    |=> (!oe_q && state_q == ST_IDLE));
  assert_nack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK && scl_fall_i && mack_q && !start_i && !stop_i)
    |=> (!oe_q && state_q == ST_IDLE));
  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);
  assert_we_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h32,
  parameter int         DW       = 8,
  parameter int         AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_ctrl #(.SLV_ADDR(SLV_ADDR), .DW(DW), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .rdata_i(reg_rdata_i),
    .sda_oe_o, .we_o(reg_we_o), .wdata_o(reg_wdata_o),
    .ptr_load_o(ptr_load), .ptr_val_o(ptr_val), .ptr_inc_o(ptr_inc)
  );

  i2c_reg_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(ptr_val), .inc_i(ptr_inc),
    .ptr_o(reg_addr_o)
  );
endmodule

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
  localparam logic [6:0] SA = 7'h32;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, we;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  wire  sda_line = m_sda & ~sda_oe;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  logic [3:0] exp_ptr;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 5);
  endfunction

  assign rdata = mem[addr];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    else if (we) mem[addr] <= wdata;
  end

  i2c_reg_slave #(.SLV_ADDR(SA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  // monitors for R10 and R11
  logic prev_oe = 1'b0, prev_we = 1'b0;
  int mon_err10 = 0, mon_err11 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_oe && m_scl) mon_err10++;
      if (we && prev_we) mon_err11++;
    end
    prev_oe = sda_oe;
    prev_we = we;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); b = sda_line; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(mack);
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < 16; i++)
      check(mem[i] === exp_mem[i], req, mem[i], exp_mem[i]);
  endtask

  task automatic wr_burst(input logic [3:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({SA, 1'b0}, ack); check(ack == 1'b0, "R2 addr ack", ack, 0);
    send_byte({4'h0, a}, ack);  check(ack == 1'b0, "R4 reg ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); check(ack == 1'b0, "R4 data ack", ack, 0);
      exp_mem[4'(a + k)] = d;
    end
    bus_stop();
    exp_ptr = 4'(a + n);
    check_mem("R4 R5 burst contents");
  endtask

  task automatic rd_addr(input logic [3:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({SA, 1'b0}, ack); check(ack == 1'b0, "R2 addr ack", ack, 0);
    send_byte({4'h0, a}, ack);  check(ack == 1'b0, "R4 reg ack", ack, 0);
    bus_start();
    send_byte({SA, 1'b1}, ack); check(ack == 1'b0, "R6 read addr ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, (k == n - 1));
      check(d === exp_mem[4'(a + k)], (k == 0) ? "R6 first byte" : "R7 next byte",
            d, exp_mem[4'(a + k)]);
    end
    bus_stop();
    exp_ptr = 4'(a + n);
  endtask

  task automatic rd_cur(input int n, input bit extra_clocks);
    logic ack, b;
    logic [7:0] d;
    bus_start();
    send_byte({SA, 1'b1}, ack); check(ack == 1'b0, "R9 read ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, (k == n - 1));
      check(d === exp_mem[4'(exp_ptr + k)], "R9 current-address byte",
            d, exp_mem[4'(exp_ptr + k)]);
    end
    exp_ptr = 4'(exp_ptr + n);
    if (extra_clocks) begin
      for (int i = 0; i < 9; i++) begin
        bit_in(b);
        check(b == 1'b1, "R8 released after NACK", b, 1);
      end
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h1c2e55));
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    exp_ptr = 4'h0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && we == 1'b0, "R1 reset idle", {sda_oe, we}, 0);
    check(addr == 4'h0, "R9 reset pointer", addr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: pointer-less read straight after reset starts at register 0
    rd_cur(2, 1'b0);
    // R5: burst across the wrap point
    wr_burst(4'd14, 4);
    check(exp_ptr == 4'd2, "R5 wrap model", exp_ptr, 2);
    rd_cur(1, 1'b0);
    // R8: NACK then more clocks, slave stays off the line
    rd_addr(4'd15, 2);
    rd_cur(1, 1'b1);

    // R3: foreign address, write attempt
    bus_start();
    send_byte({SA ^ 7'h05, 1'b0}, ack); check(ack == 1'b1, "R3 no ack", ack, 1);
    send_byte(8'h03, ack);              check(ack == 1'b1, "R3 no ack reg", ack, 1);
    send_byte(8'hA5, ack);              check(ack == 1'b1, "R3 no ack data", ack, 1);
    bus_stop();
    check_mem("R3 no write");
    // R3: foreign address, read attempt
    bus_start();
    send_byte({SA ^ 7'h40, 1'b1}, ack); check(ack == 1'b1, "R3 no ack read", ack, 1);
    recv_byte(d, 1'b1);                 check(d == 8'hFF, "R3 bus idle", d, 8'hFF);
    bus_stop();
    // R1: START mid-byte restarts address reception
    bus_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    rd_cur(1, 1'b0);

    for (int it = 0; it < 24; it++) begin
      case ($urandom_range(0, 2))
        0: wr_burst(4'($urandom_range(0, 15)), $urandom_range(1, 5));
        1: rd_addr(4'($urandom_range(0, 15)), $urandom_range(1, 5));
        default: rd_cur($urandom_range(1, 5), 1'b0);
      endcase
    end

    check(mon_err10 == 0, "R10 drive changes with SCL low", mon_err10, 0);
    check(mon_err11 == 0, "R11 single-cycle strobe", mon_err11, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule